// File: doc/BRIEF.md
# Reordering Error Magnitude Evaluator

This block turns a stream of symbol positions from one codeword into error magnitudes for the correction step of a Reed-Solomon decoder over GF(2^8). Each position arrives with a flag that says whether the root search flagged it as an error. Flagged positions go to an iterative evaluation unit. That unit computes the evaluator polynomial and the odd part of the locator polynomial at the inverse field element of the position, inverts the second value and multiplies the two. Clean positions go to a one-cycle path that answers zero.

The two paths run side by side, so a run of clean positions keeps flowing while the slow unit works on an error. A one-bit order queue, written when each position is accepted, tells the output merge which path holds the next result. Results therefore leave in arrival order.

Evaluator and locator coefficients are written beforehand through a simple write port. They must stay unchanged while positions of the codeword are in flight.

Top module: `err_mag_ooo`

## Requirements
- R1: While reset is asserted and after it is released, `mag_valid` is 0. No later than 3 cycles after `rst_n` rises, `pos_ready` is 1 while no queue is full.
- R2: A position accepted with `pos_err`=0 yields an output with `mag_data`=0 and `mag_loc` equal to its position.
- R3: A position p (0..254) accepted with `pos_err`=1 yields `mag_loc`=p and `mag_data`=N·D^-1 in GF(2^8), computed with the field polynomial 0x11D and alpha=0x02. Here X=alpha^(255-p), N=sum over j=0..T-1 of W_j·X^j, and D=sum over odd j<=T of L_j·X^(j-1). W_j is written with `coef_sel`=0 and `coef_idx`=j. L_j is written with `coef_sel`=1 and `coef_idx`=j. A write takes effect when `coef_we` is high at a clock edge. Even-indexed L writes have no effect on any result.
- R4: If D is 0 for an error position, `mag_data` is 0.
- R5: Outputs appear in exactly the order in which positions were accepted, whatever the mix of error and clean positions.
- R6: Clean positions are accepted on consecutive cycles while the slow unit is busy, as long as the order queue and the clean-path queue have room.
- R7: With all queues empty and `mag_ready` high, an error position appears on the output T+18 cycles after the edge that accepts it. The slow unit is busy for T+16 cycles per position.
- R8: `pos_ready` is 0 whenever the order queue is full or the queue of the path named by `pos_err` is full. With `mag_ready` held low, exactly min(ORD_DEPTH, FAST_DEPTH) clean positions are accepted.
- R9: While `mag_valid` is 1 and `mag_ready` is 0, the output stays valid and `mag_loc` and `mag_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 1 | 0 = evaluator coefficient, 1 = locator coefficient |
| coef_idx | input | $clog2(T+1) | Coefficient index |
| coef_data | input | 8 | Coefficient value |
| pos_valid | input | 1 | Position offered |
| pos_ready | output | 1 | Position accepted this cycle when valid |
| pos_loc | input | 8 | Symbol position |
| pos_err | input | 1 | 1 = position is an error location |
| mag_valid | output | 1 | Result available |
| mag_ready | input | 1 | Result consumed this cycle when valid |
| mag_loc | output | 8 | Position of the result |
| mag_data | output | 8 | Error magnitude |

## Verification
The bench builds the block with T=4, the field polynomial 0x11D, an order queue of 16, a clean-path queue of 8, a slow input queue of 4 and a slow output queue of 2. With T=4 the Horner loop runs over four evaluator terms and two odd locator terms, so a wrong term index or a missing odd term changes the checked magnitudes. A one-error latency of 22 cycles keeps the reordering window short enough to pile clean positions behind an error. With the clean queue smaller than the order queue, a held-off output fills the clean queue first, which makes the stall count a direct measure of that queue's depth.

// File: rtl/err_mag_pkg.sv
`timescale 1ns/1ps
package err_mag_pkg;

  localparam int SYM_W = 8;
  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXP, ST_HORN, ST_INV, ST_FIN, ST_DONE
  } core_st_t;

  // Shift-and-add product in GF(2^8); red holds the low byte of the field polynomial
  function automatic sym_t gf_mul(input sym_t a, input sym_t b, input sym_t red);
    sym_t p;
    sym_t s;
    p = '0;
    s = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ s;
      s = s[SYM_W-1] ? ({s[SYM_W-2:0], 1'b0} ^ red) : {s[SYM_W-2:0], 1'b0};
    end
    return p;
  endfunction

endpackage

// File: rtl/err_mag_fifo.sv
`timescale 1ns/1ps
module err_mag_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign dout  = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push) wr_n = (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_n = (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) !(push && full));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty));

endmodule

// File: rtl/err_mag_slow_core.sv
`timescale 1ns/1ps
module err_mag_slow_core
  import err_mag_pkg::*;
#(
  parameter int         T    = 4,
  parameter logic [8:0] POLY = 9'h11D
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  sym_t                            in_loc,
  output logic                            in_take,
  input  logic [T-1:0][SYM_W-1:0]         omega,
  input  logic [(T+1)/2-1:0][SYM_W-1:0]   lam_odd,
  output logic                            out_valid,
  output sym_t                            out_loc,
  output sym_t                            out_mag,
  input  logic                            out_take,
  output logic                            busy
);
  localparam int   NODD     = (T+1)/2;
  localparam int   STEP_MAX = (T > 8) ? T : 8;
  localparam int   SW       = $clog2(STEP_MAX);
  localparam sym_t RED      = POLY[7:0];
  localparam int   LAT      = T + 16;

  core_st_t    st_q, st_n;
  logic [SW-1:0] step_q, step_n;
  sym_t loc_q, loc_n, x_q, x_n, num_q, num_n, den_q, den_n, inv_q, inv_n, res_q, res_n;
  sym_t expo, om_sel, od_sel, x_sq;
  logic ebit;

  assign expo = 8'hFF - loc_q;
  assign ebit = expo[3'd7 - step_q[2:0]];
  assign x_sq = gf_mul(x_q, x_q, RED);

  always_comb begin
    om_sel = '0;
    for (int j = 0; j < T; j++)
      if (step_q == SW'(j)) om_sel = omega[j];
    od_sel = '0;
    for (int m = 0; m < NODD; m++)
      if (step_q == SW'(m)) od_sel = lam_odd[m];
  end

  always_comb begin
    st_n = st_q; step_n = step_q; loc_n = loc_q; x_n = x_q;
    num_n = num_q; den_n = den_q; inv_n = inv_q; res_n = res_q;
    in_take = 1'b0;
    unique case (st_q)
      ST_IDLE: if (in_valid) begin
        in_take = 1'b1;
        loc_n   = in_loc;
        x_n     = 8'h01;
        step_n  = '0;
        st_n    = ST_EXP;
      end
      ST_EXP: begin
        x_n = gf_mul(x_sq, ebit ? 8'h02 : 8'h01, RED);
        if (step_q == SW'(7)) begin
          st_n = ST_HORN; step_n = SW'(T-1); num_n = '0; den_n = '0;
        end else step_n = step_q + 1'b1;
      end
      ST_HORN: begin
        num_n = gf_mul(num_q, x_q, RED) ^ om_sel;
        den_n = gf_mul(den_q, x_sq, RED) ^ od_sel;
        if (step_q == '0) begin
          st_n = ST_INV; inv_n = 8'h01;
        end else step_n = step_q - 1'b1;
      end
      ST_INV: begin
        inv_n = gf_mul(gf_mul(inv_q, inv_q, RED), den_q, RED);
        if (step_q == SW'(6)) st_n = ST_FIN;
        else step_n = step_q + 1'b1;
      end
      ST_FIN: begin
        res_n = gf_mul(num_q, gf_mul(inv_q, inv_q, RED), RED);
        st_n  = ST_DONE;
      end
      ST_DONE: if (out_take) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; step_q <= '0; loc_q <= '0; x_q <= '0;
      num_q <= '0; den_q <= '0; inv_q <= '0; res_q <= '0;
    end else begin
      st_q <= st_n; step_q <= step_n; loc_q <= loc_n; x_q <= x_n;
      num_q <= num_n; den_q <= den_n; inv_q <= inv_n; res_q <= res_n;
    end
  end

  assign out_valid = (st_q == ST_DONE);
  assign out_loc   = loc_q;
  assign out_mag   = res_q;
  assign busy      = (st_q != ST_IDLE);

  // Busy-time counter kept for the latency check below
  logic [7:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (in_take) lat_q <= '0;
    else if (busy && st_q != ST_DONE) lat_q <= lat_q + 1'b1;
  end

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_DONE) |-> lat_q == 8'(LAT));
  a_r4_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIN && den_q == '0) |=> res_q == '0);

endmodule

// File: rtl/err_mag_ooo.sv
`timescale 1ns/1ps
module err_mag_ooo
  import err_mag_pkg::*;
#(
  parameter int         T          = 4,
  parameter logic [8:0] POLY       = 9'h11D,
  parameter int         ORD_DEPTH  = 16,
  parameter int         FAST_DEPTH = 8,
  parameter int         SLOW_DEPTH = 4,
  parameter int         OUT_DEPTH  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    coef_we,
  input  logic                    coef_sel,
  input  logic [$clog2(T+1)-1:0]  coef_idx,
  input  logic [7:0]              coef_data,
  input  logic                    pos_valid,
  output logic                    pos_ready,
  input  logic [7:0]              pos_loc,
  input  logic                    pos_err,
  output logic                    mag_valid,
  input  logic                    mag_ready,
  output logic [7:0]              mag_loc,
  output logic [7:0]              mag_data
);
  localparam int IDX_W = $clog2(T+1);
  localparam int NODD  = (T+1)/2;

  // Asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // Coefficient storage: evaluator terms and odd locator terms only
  logic [T-1:0][7:0]    om_q;
  logic [NODD-1:0][7:0] lo_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      om_q <= '0;
      lo_q <= '0;
    end else if (coef_we) begin
      for (int j = 0; j < T; j++)
        if (!coef_sel && coef_idx == IDX_W'(j)) om_q[j] <= coef_data;
      for (int m = 0; m < NODD; m++)
        if (coef_sel && coef_idx == IDX_W'(2*m+1)) lo_q[m] <= coef_data;
    end
  end

  // Dispatcher
  logic ord_full, ord_empty, ord_tag, fast_full, fast_empty, sin_full, sin_empty;
  logic sout_full, sout_empty, acc, fire, core_take, core_valid, core_busy;
  logic [$clog2(ORD_DEPTH+1)-1:0]  ord_cnt;
  logic [$clog2(FAST_DEPTH+1)-1:0] fast_cnt;
  logic [$clog2(SLOW_DEPTH+1)-1:0] sin_cnt;
  logic [$clog2(OUT_DEPTH+1)-1:0]  sout_cnt;
  sym_t fast_loc, sin_loc, core_loc, core_mag, sout_loc, sout_mag;

  assign pos_ready = rst_i_n && !ord_full && (pos_err ? !sin_full : !fast_full);
  assign acc       = pos_valid && pos_ready;

  err_mag_fifo #(.W(1), .DEPTH(ORD_DEPTH)) u_ord (
    .clk, .rst_n(rst_i_n), .push(acc), .din(pos_err), .pop(fire),
    .dout(ord_tag), .full(ord_full), .empty(ord_empty), .count(ord_cnt));

  // One-cycle clean path: the queue slot itself is the single stage
  err_mag_fifo #(.W(8), .DEPTH(FAST_DEPTH)) u_fast (
    .clk, .rst_n(rst_i_n), .push(acc && !pos_err), .din(pos_loc), .pop(fire && !ord_tag),
    .dout(fast_loc), .full(fast_full), .empty(fast_empty), .count(fast_cnt));

  err_mag_fifo #(.W(8), .DEPTH(SLOW_DEPTH)) u_sin (
    .clk, .rst_n(rst_i_n), .push(acc && pos_err), .din(pos_loc), .pop(core_take),
    .dout(sin_loc), .full(sin_full), .empty(sin_empty), .count(sin_cnt));

  err_mag_slow_core #(.T(T), .POLY(POLY)) u_core (
    .clk, .rst_n(rst_i_n), .in_valid(!sin_empty), .in_loc(sin_loc), .in_take(core_take),
    .omega(om_q), .lam_odd(lo_q), .out_valid(core_valid), .out_loc(core_loc),
    .out_mag(core_mag), .out_take(!sout_full), .busy(core_busy));

  err_mag_fifo #(.W(16), .DEPTH(OUT_DEPTH)) u_sout (
    .clk, .rst_n(rst_i_n), .push(core_valid && !sout_full), .din({core_loc, core_mag}),
    .pop(fire && ord_tag), .dout({sout_loc, sout_mag}), .full(sout_full),
    .empty(sout_empty), .count(sout_cnt));

  // Ordered merge
  assign mag_valid = !ord_empty && (ord_tag ? !sout_empty : !fast_empty);
  assign fire      = mag_valid && mag_ready;
  assign mag_loc   = ord_tag ? sout_loc : fast_loc;
  assign mag_data  = ord_tag ? sout_mag : '0;

  a_r5_tag_balance: assert property (@(posedge clk) disable iff (!rst_i_n)
    8'(ord_cnt) == 8'(fast_cnt) + 8'(sin_cnt) + 8'(core_busy) + 8'(sout_cnt));
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mag_valid && !mag_ready) |=> (mag_valid && $stable(mag_loc) && $stable(mag_data)));
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (rst_i_n) !mag_valid);

endmodule

// File: tb/err_mag_ooo_tb.sv
`timescale 1ns/1ps
module err_mag_ooo_tb_top;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0, coef_sel = 1'b0;
  logic [2:0] coef_idx = '0;
  logic [7:0] coef_data = '0;
  logic pos_valid = 1'b0, pos_err = 1'b0, mag_ready = 1'b0;
  logic [7:0] pos_loc = '0;
  logic pos_ready, mag_valid;
  logic [7:0] mag_loc, mag_data;

  always #2 clk = ~clk;

  err_mag_ooo dut_i (
    .clk, .rst_n, .coef_we, .coef_sel, .coef_idx, .coef_data,
    .pos_valid, .pos_ready, .pos_loc, .pos_err,
    .mag_valid, .mag_ready, .mag_loc, .mag_data);

  int checks = 0, errors = 0, cyc = 0, exp_n = 0, got_n = 0, acc_cyc = 0;
  logic [7:0] exp_loc [0:255];
  logic [7:0] exp_mag [0:255];
  logic [7:0] got_loc [0:255];
  logic [7:0] got_mag [0:255];
  int         got_cyc [0:255];
  logic [7:0] om [0:T-1];
  logic [7:0] lm [0:T];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (mag_valid && mag_ready && got_n < 256) begin
      got_loc[got_n] = mag_loc;
      got_mag[got_n] = mag_data;
      got_cyc[got_n] = cyc;
      got_n++;
    end
  end

  // Full product then reduction from the top bit down
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h11D << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] model_mag(input logic [7:0] loc);
    logic [7:0] x, xp, num, den, inv;
    x = 8'h01;
    for (int i = 0; i < 255 - int'(loc); i++) x = bmul(x, 8'h02);
    num = '0; xp = 8'h01;
    for (int j = 0; j < T; j++) begin num ^= bmul(om[j], xp); xp = bmul(xp, x); end
    den = '0; xp = 8'h01;
    for (int j = 1; j <= T; j += 2) begin den ^= bmul(lm[j], xp); xp = bmul(xp, bmul(x, x)); end
    inv = '0;
    for (int b = 1; b < 256; b++) if (bmul(den, 8'(b)) == 8'h01) inv = 8'(b);
    return bmul(num, inv);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr_coef(input logic sel, input int idx, input logic [7:0] d);
    coef_we = 1'b1; coef_sel = sel; coef_idx = 3'(idx); coef_data = d;
    @(negedge clk);
    coef_we = 1'b0;
    if (!sel) om[idx] = d; else lm[idx] = d;
  endtask

  task automatic push(input logic [7:0] loc, input logic err, input int max_w,
                      output int waits, output bit ok);
    pos_loc = loc; pos_err = err; pos_valid = 1'b1; waits = 0; ok = 1'b0;
    while (!ok && waits < max_w) begin
      #1;
      if (pos_ready) begin
        exp_loc[exp_n] = loc;
        exp_mag[exp_n] = err ? model_mag(loc) : 8'h00;
        exp_n++;
        acc_cyc = cyc;
        ok = 1'b1;
      end else waits++;
      @(negedge clk);
    end
    pos_valid = 1'b0;
  endtask

  task automatic drain_and_compare(input int from, input string req);
    int w = 0;
    while (got_n < exp_n && w < 800) begin @(negedge clk); w++; end
    chk(got_n == exp_n, req, "output count", got_n, exp_n);
    for (int i = from; i < exp_n && i < got_n; i++) begin
      chk(got_loc[i] == exp_loc[i], req, $sformatf("loc of result %0d", i), got_loc[i], exp_loc[i]);
      chk(got_mag[i] == exp_mag[i], req, $sformatf("magnitude of result %0d", i), got_mag[i], exp_mag[i]);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(mag_valid == 1'b0, "R1", "mag_valid in reset", mag_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(pos_ready == 1'b1, "R1", "pos_ready after release", pos_ready, 1);
    chk(mag_valid == 1'b0, "R1", "mag_valid after release", mag_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_load();
    for (int j = 0; j <= T; j++) lm[j] = '0;
    wr_coef(0, 0, 8'h12); wr_coef(0, 1, 8'h34); wr_coef(0, 2, 8'h56); wr_coef(0, 3, 8'h78);
    wr_coef(1, 1, 8'h9A); wr_coef(1, 3, 8'hDE);
    // Even-indexed locator writes must not matter (R3); the model ignores them too
    wr_coef(1, 0, 8'h01); wr_coef(1, 2, 8'hBC); wr_coef(1, 4, 8'hF0);
  endtask

  task automatic t_clean();
    int from = exp_n, w; bit ok;
    mag_ready = 1'b1;
    push(8'd5, 0, 20, w, ok); push(8'd200, 0, 20, w, ok);
    push(8'd0, 0, 20, w, ok); push(8'd254, 0, 20, w, ok);
    drain_and_compare(from, "R2");
  endtask

  task automatic t_single_err();
    int from = exp_n, w, a; bit ok;
    mag_ready = 1'b1;
    push(8'd17, 1, 20, w, ok);
    a = acc_cyc;
    drain_and_compare(from, "R3");
    chk(got_cyc[from] - (a + 1) == T + 18, "R7", "error latency", got_cyc[from] - (a + 1), T + 18);
  endtask

  task automatic t_mixed();
    int from = exp_n, w, stalls = 0; bit ok;
    logic [7:0] locs [12] = '{8'd3, 8'd90, 8'd91, 8'd250, 8'd7, 8'd128, 8'd0, 8'd1, 8'd66, 8'd201, 8'd202, 8'd33};
    logic       errs [12] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    mag_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      push(locs[i], errs[i], 200, w, ok);
      if (!errs[i]) stalls += w;
    end
    chk(stalls == 0, "R6", "clean stalls behind busy unit", stalls, 0);
    drain_and_compare(from, "R5");
  endtask

  task automatic t_backpressure();
    int from = exp_n, w, n_ok = 0; bit ok;
    logic [7:0] first;
    mag_ready = 1'b0;
    for (int i = 0; i < 10; i++) begin
      push(8'(40 + i), 0, 3, w, ok);
      if (ok) n_ok++;
    end
    chk(n_ok == 8, "R8", "clean positions accepted while held", n_ok, 8);
    #1;
    chk(pos_ready == 1'b0, "R8", "pos_ready with full clean queue", pos_ready, 0);
    first = mag_loc;
    chk(mag_valid == 1'b1, "R9", "valid while held", mag_valid, 1);
    repeat (4) @(negedge clk);
    #1;
    chk(mag_valid == 1'b1 && mag_loc == first, "R9", "held loc", mag_loc, first);
    chk(first == 8'd40, "R9", "held head loc", first, 40);
    @(negedge clk);
    mag_ready = 1'b1;
    drain_and_compare(from, "R5");
  endtask

  task automatic t_zero_den();
    int from = exp_n, w; bit ok;
    wr_coef(1, 1, 8'h00); wr_coef(1, 3, 8'h00);
    mag_ready = 1'b1;
    push(8'd40, 1, 50, w, ok); push(8'd99, 1, 50, w, ok); push(8'd12, 0, 50, w, ok);
    drain_and_compare(from, "R4");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_load();
    t_clean();
    t_single_err();
    t_mixed();
    t_backpressure();
    t_zero_den();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule